// File: doc/BRIEF.md
# Calendar Time-of-Year Counter

This block keeps wall-clock time for a chip. A slow oscillator tick, delivered as a one-cycle pulse in the system clock domain, drives a prescaler. Each time the prescaler wraps, the calendar advances by one second. Seconds, minutes, hours, day of month and month sit together in one packed 32-bit word. The full calendar year (for example 2024) is held in its own 32-bit word. Month, day and leap-year rollover follow the Gregorian calendar from 1900 through 2099.

Software reaches the block through a small word-addressed register port with these word indices:
- 0: divisor (trim)
- 1: time load
- 2: year load
- 3: time readback
- 4: year readback
- 5: control/status

Writes to the load and divisor registers are not applied at once. They wait for the next oscillator tick boundary. A busy flag in the control register stays set until that handoff has completed. Reading the time word captures the year at the same instant, so software always pairs a time with the matching year.

Top module: `time_of_year_counter`

## Requirements
- R1: After reset, the time readback is 0x0420_0000 (month 1, day 1, 00:00:00), the year readback is 1900, the divisor reads 32767 and the control register reads 0.
- R2: The time word places month in [31:26], day in [25:21], hour in [20:16], minute in [15:10] and second in [9:4], all plain binary. Bits [3:0] carry bits [14:11] of the prescaler count, and they read zero right after a time load.
- R3: A write to word 1 or word 2 sets control bit 0. The next oscillator tick loads the value into the live calendar, clears bit 0 and restarts the prescaler count from zero.
- R4: A write to word 0 sets control bit 4. The new divisor becomes active on the next oscillator tick, which also clears bit 4 and restarts the prescaler.
- R5: While counting is enabled, the second advances once every divisor+1 oscillator ticks. With the default divisor of 32767, this is once every 32768 ticks.
- R6: Writing control bit 8 as 1 enables counting. While enabled, control bits 8 and 5 both read 1. While disabled, ticks do not advance the time.
- R7: Rollover cascades in this order: second 59 to 0, then minute 59 to 0, then hour 23 to 0, then day past the month length to 1, then month 12 to 1, and finally the year increments.
- R8: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is divisible by 4 and is not 1900, and 28 days otherwise. All other months have 31 days.
- R9: Reading word 3 latches the live year. A later read of word 4 returns that latched year even if the calendar has rolled over in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |

## Verification
The hardest states to reach are the rare rollovers: end of year, February in 1900 versus a leap year, and 30-day months. With the default divisor, reaching any of them would take tens of thousands of ticks per second. The bench therefore shrinks the divisor to 3 through the busy handoff. It then loads a time one second before each boundary and runs exactly four ticks. The year snapshot is tested by reading the time just before a year rollover and reading the year just after it.

// File: rtl/tyc_pkg.sv
package tyc_pkg;
  localparam logic [2:0] A_TRIM    = 3'd0;
  localparam logic [2:0] A_TIME_WR = 3'd1;
  localparam logic [2:0] A_YEAR_WR = 3'd2;
  localparam logic [2:0] A_TIME_RD = 3'd3;
  localparam logic [2:0] A_YEAR_RD = 3'd4;
  localparam logic [2:0] A_CTRL    = 3'd5;

  localparam logic [31:0] YEAR_RST = 32'd1900;

  typedef struct packed {
    logic [5:0] month;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [5:0] second;
  } cal_t;

  function automatic logic [4:0] month_len(input logic [5:0] mon, input logic [31:0] yr);
    logic leap;
    leap = (yr[1:0] == 2'b00) && (yr != 32'd1900);
    case (mon)
      6'd2:                        month_len = leap ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11:     month_len = 5'd30;
      default:                     month_len = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/tyc_prescaler.sv
module tyc_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             sec_adv,
  output logic [3:0]       frac
);
  localparam int FRAC_HI = CNT_W - 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = tick;

  always_comb begin
    cnt_d   = cnt_q;
    sec_adv = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q >= limit) begin
        cnt_d   = '0;
        sec_adv = tick;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign frac = cnt_q[FRAC_HI -: 4];
endmodule

// File: rtl/tyc_calendar.sv
module tyc_calendar
  import tyc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_time,
  input  logic        load_year,
  input  cal_t        time_in,
  input  logic [31:0] year_in,
  input  logic        adv,
  output cal_t        cal_q,
  output logic [31:0] year_q
);
  cal_t        cal_d;
  logic [31:0] year_d;
  logic        year_inc;
  logic [4:0]  dim;
  logic        upd_en;

  assign dim    = month_len(cal_q.month, year_q);
  assign upd_en = load_time | load_year | adv;

  always_comb begin
    cal_d    = cal_q;
    year_inc = 1'b0;
    if (load_time) begin
      cal_d = time_in;
    end else if (adv) begin
      if (cal_q.second >= 6'd59) begin
        cal_d.second = '0;
        if (cal_q.minute >= 6'd59) begin
          cal_d.minute = '0;
          if (cal_q.hour >= 5'd23) begin
            cal_d.hour = '0;
            if (cal_q.day >= dim) begin
              cal_d.day = 5'd1;
              if (cal_q.month >= 6'd12) begin
                cal_d.month = 6'd1;
                year_inc    = 1'b1;
              end else begin
                cal_d.month = cal_q.month + 6'd1;
              end
            end else begin
              cal_d.day = cal_q.day + 5'd1;
            end
          end else begin
            cal_d.hour = cal_q.hour + 5'd1;
          end
        end else begin
          cal_d.minute = cal_q.minute + 6'd1;
        end
      end else begin
        cal_d.second = cal_q.second + 6'd1;
      end
    end
  end

  always_comb begin
    year_d = year_q;
    if (load_year)     year_d = year_in;
    else if (year_inc) year_d = year_q + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= '{month: 6'd1, day: 5'd1, hour: '0, minute: '0, second: '0};
      year_q <= YEAR_RST;
    end else if (upd_en) begin
      cal_q  <= cal_d;
      year_q <= year_d;
    end
  end
endmodule

// File: rtl/tyc_regs.sv
module tyc_regs
  import tyc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TRIM_RST = 32767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [31:0]      live_time,
  input  logic [31:0]      live_year,
  output logic [31:0]      bus_rdata,
  output cal_t             time_buf,
  output logic [31:0]      year_buf,
  output logic             load_time,
  output logic             load_year,
  output logic             restart,
  output logic [CNT_W-1:0] trim_q,
  output logic             en_q,
  output logic             wr_busy,
  output logic             trim_busy
);
  logic             wr_time, wr_year, wr_trim, wr_ctrl;
  logic             time_pend, year_pend, trim_pend;
  logic             time_pend_d, year_pend_d, trim_pend_d;
  logic [CNT_W-1:0] trim_buf;
  logic             apply_trim;
  logic [31:0]      snap_year;
  logic [31:0]      rdata_d, rdata_q;
  logic [31:0]      ctrl_word;

  assign wr_time = bus_wr && (bus_addr == A_TIME_WR);
  assign wr_year = bus_wr && (bus_addr == A_YEAR_WR);
  assign wr_trim = bus_wr && (bus_addr == A_TRIM);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);

  assign load_time  = time_pend & osc_tick;
  assign load_year  = year_pend & osc_tick;
  assign apply_trim = trim_pend & osc_tick;
  assign restart    = load_time | load_year | apply_trim;

  assign time_pend_d = wr_time | (time_pend & ~osc_tick);
  assign year_pend_d = wr_year | (year_pend & ~osc_tick);
  assign trim_pend_d = wr_trim | (trim_pend & ~osc_tick);

  assign wr_busy   = time_pend | year_pend;
  assign trim_busy = trim_pend;

  assign ctrl_word = {23'd0, en_q, 2'b00, en_q, trim_busy, 3'b000, wr_busy};

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (bus_addr)
        A_TRIM:    rdata_d = 32'(trim_q);
        A_TIME_RD: rdata_d = live_time;
        A_YEAR_RD: rdata_d = snap_year;
        A_CTRL:    rdata_d = ctrl_word;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_pend <= 1'b0;
      year_pend <= 1'b0;
      trim_pend <= 1'b0;
    end else begin
      time_pend <= time_pend_d;
      year_pend <= year_pend_d;
      trim_pend <= trim_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_buf <= '0;
      year_buf <= '0;
      trim_buf <= '0;
    end else begin
      if (wr_time) time_buf <= cal_t'(bus_wdata[31:4]);
      if (wr_year) year_buf <= bus_wdata;
      if (wr_trim) trim_buf <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q    <= CNT_W'(TRIM_RST);
      en_q      <= 1'b0;
      snap_year <= YEAR_RST;
      rdata_q   <= '0;
    end else begin
      if (apply_trim)                      trim_q    <= trim_buf;
      if (wr_ctrl)                         en_q      <= bus_wdata[8];
      if (bus_rd && bus_addr == A_TIME_RD) snap_year <= live_year;
      if (bus_rd)                          rdata_q   <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/time_of_year_counter.sv
module time_of_year_counter
  import tyc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TRIM_RST = 32767
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_tick,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic [1:0]       rst_sync;
  logic             rst_ni;
  cal_t             time_buf, cal_q;
  logic [31:0]      year_buf, year_q;
  logic             load_time, load_year, restart;
  logic [CNT_W-1:0] trim_q;
  logic             en_q, wr_busy, trim_busy, sec_adv;
  logic [3:0]       frac;
  logic [31:0]      live_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign live_time = {cal_q, frac};

  tyc_regs #(.CNT_W(CNT_W), .TRIM_RST(TRIM_RST)) u_regs (
    .clk(clk), .rst_n(rst_ni), .osc_tick(osc_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .live_time(live_time), .live_year(year_q),
    .bus_rdata(bus_rdata), .time_buf(time_buf), .year_buf(year_buf),
    .load_time(load_time), .load_year(load_year), .restart(restart),
    .trim_q(trim_q), .en_q(en_q), .wr_busy(wr_busy), .trim_busy(trim_busy)
  );

  tyc_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk(clk), .rst_n(rst_ni), .tick(osc_tick), .run(en_q),
    .restart(restart), .limit(trim_q), .sec_adv(sec_adv), .frac(frac)
  );

  tyc_calendar u_cal (
    .clk(clk), .rst_n(rst_ni), .load_time(load_time), .load_year(load_year),
    .time_in(time_buf), .year_in(year_buf), .adv(sec_adv),
    .cal_q(cal_q), .year_q(year_q)
  );
endmodule

// File: rtl/tyc_checker.sv
module tyc_checker
  import tyc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       osc_tick,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic       wr_busy,
  input logic       trim_busy,
  input logic       sec_adv,
  input logic       load_time,
  input logic [5:0] second,
  input logic [5:0] month
);
  assert_wr_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_TIME_WR || bus_addr == A_YEAR_WR)) |=> wr_busy);

  assert_busy_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && osc_tick && !(bus_wr && (bus_addr == A_TIME_WR || bus_addr == A_YEAR_WR)))
    |=> !wr_busy);

  assert_trim_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TRIM) |=> trim_busy);

  assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(second));

  assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (second == 6'd59 && sec_adv && !load_time) |=> (second == 6'd0));

  assert_month_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (month >= 6'd1 && month <= 6'd12));
endmodule

bind time_of_year_counter tyc_checker u_chk (
  .clk(clk), .rst_n(rst_ni), .osc_tick(osc_tick), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wr_busy(wr_busy), .trim_busy(trim_busy),
  .sec_adv(sec_adv), .load_time(load_time), .second(cal_q.second),
  .month(cal_q.month)
);

// File: tb/time_of_year_counter_test.sv
`timescale 1ns/1ps
module time_of_year_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  time_of_year_counter uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] tw(int mo, int d, int h, int mi, int s);
    return 32'((mo << 26) | (d << 21) | (h << 16) | (mi << 10) | (s << 4));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic set_time(logic [31:0] t, int yr);
    wr(3'd1, t); wr(3'd2, 32'(yr)); ticks(1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd3, v); chk("R1 time", v, 32'h0420_0000);
    rd(3'd4, v); chk("R1 year", v, 32'd1900);
    rd(3'd0, v); chk("R1 trim", v, 32'd32767);
    rd(3'd5, v); chk("R1 ctrl", v, 32'd0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    ticks(10);
    rd(3'd3, v); chk("R6 disabled no advance", v, 32'h0420_0000);
    wr(3'd5, 32'h100);
    rd(3'd5, v); chk("R6 ctrl running", v, 32'h120);
  endtask

  task automatic t_default_rate;
    logic [31:0] v;
    ticks(2048);
    rd(3'd3, v); chk("R2 subsec after 2048", v, 32'h0420_0001);
    ticks(30719);
    rd(3'd3, v); chk("R5 not yet a second", v, 32'h0420_000F);
    ticks(1);
    rd(3'd3, v); chk("R5 second at 32768", v, 32'h0420_0010);
  endtask

  task automatic t_trim;
    logic [31:0] v;
    wr(3'd0, 32'd3);
    rd(3'd5, v); chk("R4 trim busy", v, 32'h130);
    rd(3'd0, v); chk("R4 old divisor held", v, 32'd32767);
    ticks(1);
    rd(3'd5, v); chk("R4 busy cleared", v, 32'h120);
    rd(3'd0, v); chk("R4 new divisor", v, 32'd3);
  endtask

  task automatic t_load;
    logic [31:0] v;
    wr(3'd1, tw(2, 28, 23, 59, 58) | 32'hF);
    rd(3'd5, v); chk("R3 busy after time write", v, 32'h121);
    ticks(1);
    rd(3'd5, v); chk("R3 busy cleared", v, 32'h120);
    wr(3'd2, 32'd2024);
    rd(3'd5, v); chk("R3 busy after year write", v, 32'h121);
    ticks(1);
    rd(3'd3, v); chk("R2 loaded, subsec zero", v, tw(2, 28, 23, 59, 58));
    rd(3'd4, v); chk("R3 year loaded", v, 32'd2024);
    ticks(3);
    rd(3'd3, v); chk("R5 no advance before trim+1", v, tw(2, 28, 23, 59, 58));
    ticks(1);
    rd(3'd3, v); chk("R5 advance at trim+1", v, tw(2, 28, 23, 59, 59));
  endtask

  task automatic t_restart;
    logic [31:0] v;
    set_time(tw(5, 5, 5, 5, 5), 2030);
    ticks(2);
    wr(3'd1, tw(5, 5, 5, 5, 10));
    ticks(1);
    ticks(3);
    rd(3'd3, v); chk("R3 prescaler restarted", v, tw(5, 5, 5, 5, 10));
    ticks(1);
    rd(3'd3, v); chk("R3 count after restart", v, tw(5, 5, 5, 5, 11));
  endtask

  task automatic roll(string tag, logic [31:0] t0, int y0, logic [31:0] t1, int y1);
    logic [31:0] v;
    set_time(t0, y0);
    ticks(4);
    rd(3'd3, v); chk(tag, v, t1);
    rd(3'd4, v); chk(tag, v, 32'(y1));
  endtask

  task automatic t_cascade;
    roll("R7 min/hour carry", tw(3, 10, 10, 59, 59), 2050, tw(3, 10, 11, 0, 0), 2050);
    roll("R7 year carry", tw(12, 31, 23, 59, 59), 2023, tw(1, 1, 0, 0, 0), 2024);
    roll("R7 31-day month", tw(1, 31, 23, 59, 59), 2025, tw(2, 1, 0, 0, 0), 2025);
  endtask

  task automatic t_months;
    roll("R8 leap feb 28", tw(2, 28, 23, 59, 59), 2024, tw(2, 29, 0, 0, 0), 2024);
    roll("R8 leap feb 29", tw(2, 29, 23, 59, 59), 2024, tw(3, 1, 0, 0, 0), 2024);
    roll("R8 1900 feb", tw(2, 28, 23, 59, 59), 1900, tw(3, 1, 0, 0, 0), 1900);
    roll("R8 common feb", tw(2, 28, 23, 59, 59), 2023, tw(3, 1, 0, 0, 0), 2023);
    roll("R8 april", tw(4, 30, 23, 59, 59), 2025, tw(5, 1, 0, 0, 0), 2025);
    roll("R8 30 not last", tw(7, 30, 23, 59, 59), 2025, tw(7, 31, 0, 0, 0), 2025);
  endtask

  task automatic t_snapshot;
    logic [31:0] v;
    set_time(tw(12, 31, 23, 59, 59), 2099);
    ticks(3);
    rd(3'd3, v); chk("R9 time before wrap", v, tw(12, 31, 23, 59, 59));
    ticks(1);
    rd(3'd4, v); chk("R9 snapshot year", v, 32'd2099);
    rd(3'd3, v); chk("R9 time after wrap", v, tw(1, 1, 0, 0, 0));
    rd(3'd4, v); chk("R9 new snapshot", v, 32'd2100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_enable;
    t_default_rate;
    t_trim;
    t_load;
    t_restart;
    t_cascade;
    t_months;
    t_snapshot;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule